// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block sits inside a memory controller and walks an attached DDR2-class memory into and out of its self-refresh low-power state. Software sets a request bit to start entry. The sequencer then issues the self-refresh entry command with clock enable (CKE) driven low. It raises a status flag that software can poll, and it keeps the memory in self-refresh for at least a minimum row-active time.

The first internal access to memory space wakes the memory. The sequencer drives CKE high and clears both the status flag and the request bit. It then holds the access on a ready/stall handshake until the exit recovery time has passed. A read waits a long, fixed interval so that the memory's DLL can relock. A write waits a shorter interval that software programs. The memory clock may be gated by software. While it is gated, any access is refused with a bus error, nothing is performed externally, and the memory stays in self-refresh.

Top module: `srf_seq`

## Requirements
- R1: After reset, CKE is high, the command output is NOP (2'b00), the request bit and the status flag are low, and an access with the clock running sees ready high and error low.
- R2: A pulse on the request-set input sets the request bit at the next edge. With the bit set and the block idle, the following edge drives CKE low and presents the entry command (2'b01) for exactly one cycle, then NOP again.
- R3: The status flag rises one cycle after the entry command. It stays high while the memory is in self-refresh and is never high while CKE is high.
- R4: CKE stays low for at least TRAS_CYC cycles after the entry command. An access that arrives earlier is stalled, with ready low, and is served only after that minimum. The first cycle of the access counts towards this minimum.
- R5: An access to memory space in self-refresh, with the clock running, raises CKE. The status flag and the request bit clear at the same edge.
- R6: For a read (acc_read_i high), ready rises exactly TXSRD_CYC cycles after CKE rises.
- R7: For a write, ready rises exactly xsnr_cyc_i cycles after CKE rises. A programmed value of 0 behaves as 1.
- R8: While the memory clock is gated, an access in self-refresh sees error high and ready low. CKE stays low and the status flag stays high.
- R9: Without an access, the memory stays in self-refresh indefinitely after the minimum time.
- R10: At the end of exit, ready is high for one cycle. The block then returns to idle, where accesses with the clock running are granted at once and gated accesses get an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srf_req_set_i | input | 1 | Software write pulse that sets the request bit |
| clk_gate_i | input | 1 | Software memory-clock disable |
| xsnr_cyc_i | input | CNT_W | Exit wait in cycles before a non-read command |
| acc_valid_i | input | 1 | Internal access to memory space pending |
| acc_read_i | input | 1 | Pending access is a read |
| acc_ready_o | output | 1 | Access may proceed (stall when low) |
| acc_err_o | output | 1 | Bus error: access refused, clock gated |
| cke_o | output | 1 | Memory clock enable |
| cmd_o | output | 2 | Memory command: 00 NOP, 01 self-refresh entry |
| srf_req_o | output | 1 | Request bit readback |
| srf_active_o | output | 1 | Status: memory is in self-refresh |

## Verification
The bench raises an access in the very first self-refresh cycle and counts the CKE-low cycles. A design that skipped the minimum-time counter would wake early and give too short a count. Read and write exits are timed against 200 cycles and against the programmed count, including a programmed 0. A design that mixed up the access type, or was off by one in its counter, would show a different stall length. Gated accesses must return an error and must not wake the memory. A design that checked only the access and ignored the gate would raise CKE and clear the status flag. After each exit the request bit must read as clear; otherwise the block would re-enter self-refresh at once.

// File: rtl/srf_pkg.sv
package srf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ENTER = 3'd1,
        ST_SREF  = 3'd2,
        ST_EXITW = 3'd3,
        ST_READY = 3'd4
    } srf_state_e;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_SRE = 2'b01
    } mem_cmd_e;

endpackage

// File: rtl/srf_dncnt.sv
module srf_dncnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_s;

    cnt_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_i) begin
            nxt_d.cnt = val_i;
        end else if (dec_i && (cur_q.cnt != '0)) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign zero_o = (cur_q.cnt == '0);

    // Counter saturates at zero; keeps minimum-time and exit windows exact (R4)
    p_cnt_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && dec_i && zero_o) |=> zero_o);

endmodule

// File: rtl/srf_acc_gate.sv
module srf_acc_gate
    import srf_pkg::*;
(
    input  srf_state_e state_i,
    input  logic       valid_i,
    input  logic       gate_i,
    output logic       ready_o,
    output logic       err_o,
    output logic       wake_o
);

    logic gated_zone;

    always_comb begin
        gated_zone = (state_i == ST_IDLE) || (state_i == ST_ENTER) || (state_i == ST_SREF);
        err_o      = valid_i && gate_i && gated_zone;
        wake_o     = valid_i && !gate_i && (state_i == ST_SREF);
        ready_o    = ((state_i == ST_IDLE) && !gate_i) || (state_i == ST_READY);
    end

endmodule

// File: rtl/srf_seq.sv
module srf_seq
    import srf_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int TRAS_CYC  = 8,
    parameter int TXSRD_CYC = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srf_req_set_i,
    input  logic             clk_gate_i,
    input  logic [CNT_W-1:0] xsnr_cyc_i,
    input  logic             acc_valid_i,
    input  logic             acc_read_i,
    output logic             acc_ready_o,
    output logic             acc_err_o,
    output logic             cke_o,
    output logic [1:0]       cmd_o,
    output logic             srf_req_o,
    output logic             srf_active_o
);

    localparam int TRAS_W = $clog2(TRAS_CYC + 1);
    localparam logic [TRAS_W-1:0] TRAS_LOAD = TRAS_W'(TRAS_CYC - 1);
    localparam logic [CNT_W-1:0]  RD_LOAD   = CNT_W'(TXSRD_CYC - 1);

    typedef struct packed {
        srf_state_e st;
        logic       cke;
        logic       active;
        logic       req;
    } seq_s;

    seq_s seq_q, seq_d;

    logic             wake;
    logic             tras_zero, exit_zero;
    logic             tras_load, exit_load, exit_dec;
    logic [CNT_W-1:0] exit_val;

    srf_acc_gate i_gate (
        .state_i (seq_q.st),
        .valid_i (acc_valid_i),
        .gate_i  (clk_gate_i),
        .ready_o (acc_ready_o),
        .err_o   (acc_err_o),
        .wake_o  (wake)
    );

    srf_dncnt #(.W(TRAS_W)) i_tras_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tras_load),
        .val_i  (TRAS_LOAD),
        .dec_i  (seq_q.st == ST_SREF),
        .zero_o (tras_zero)
    );

    srf_dncnt #(.W(CNT_W)) i_exit_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (exit_load),
        .val_i  (exit_val),
        .dec_i  (exit_dec),
        .zero_o (exit_zero)
    );

    always_comb begin
        if (acc_read_i) begin
            exit_val = RD_LOAD;
        end else if (xsnr_cyc_i == '0) begin
            exit_val = '0;
        end else begin
            exit_val = xsnr_cyc_i - 1'b1;
        end
    end

    always_comb begin
        seq_d     = seq_q;
        tras_load = 1'b0;
        exit_load = 1'b0;
        exit_dec  = 1'b0;
        seq_d.req = seq_q.req | srf_req_set_i;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (seq_q.req) begin
                    seq_d.st  = ST_ENTER;
                    seq_d.cke = 1'b0;
                end
            end
            ST_ENTER: begin
                seq_d.st     = ST_SREF;
                seq_d.active = 1'b1;
                tras_load    = 1'b1;
            end
            ST_SREF: begin
                if (wake && tras_zero) begin
                    seq_d.st     = ST_EXITW;
                    seq_d.cke    = 1'b1;
                    seq_d.active = 1'b0;
                    seq_d.req    = 1'b0;
                    exit_load    = 1'b1;
                end
            end
            ST_EXITW: begin
                if (exit_zero) begin
                    seq_d.st = ST_READY;
                end else begin
                    exit_dec = 1'b1;
                end
            end
            ST_READY: begin
                seq_d.st = ST_IDLE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st     <= ST_IDLE;
            seq_q.cke    <= 1'b1;
            seq_q.active <= 1'b0;
            seq_q.req    <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cke_o        = seq_q.cke;
    assign srf_active_o = seq_q.active;
    assign srf_req_o    = seq_q.req;
    assign cmd_o        = (seq_q.st == ST_ENTER) ? CMD_SRE : CMD_NOP;

    p_sre_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_SRE) |=> (cmd_o == CMD_NOP));

    p_sre_cke_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_SRE) |-> !cke_o);

    p_status_needs_cke_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        srf_active_o |-> !cke_o);

    p_exit_clears_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> (!srf_active_o && !srf_req_o));

    p_gated_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && clk_gate_i && !cke_o) |-> (acc_err_o && !acc_ready_o));

    p_gated_no_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && clk_gate_i) |=> !cke_o);

    p_no_ready_cke_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> !acc_ready_o);

endmodule

// File: tb/test_srf_seq.sv
module test_srf_seq;

    localparam int CNT_W = 10;
    localparam int TRAS  = 8;
    localparam int TXSRD = 200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             set = 1'b0;
    logic             gate = 1'b0;
    logic [CNT_W-1:0] xsnr = '0;
    logic             valid = 1'b0;
    logic             rd = 1'b0;
    logic             ready, err, cke, req, active;
    logic [1:0]       cmd;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    srf_seq #(.CNT_W(CNT_W), .TRAS_CYC(TRAS), .TXSRD_CYC(TXSRD)) i_srf_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .srf_req_set_i (set),
        .clk_gate_i    (gate),
        .xsnr_cyc_i    (xsnr),
        .acc_valid_i   (valid),
        .acc_read_i    (rd),
        .acc_ready_o   (ready),
        .acc_err_o     (err),
        .cke_o         (cke),
        .cmd_o         (cmd),
        .srf_req_o     (req),
        .srf_active_o  (active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Request entry and check the command sequence (R2, R3)
    task automatic enter_sr();
        set = 1'b1;
        tick(1);
        set = 1'b0;
        chk("R2 req bit set", int'(req), 1);
        tick(1);
        chk("R2 cke low at entry", int'(cke), 0);
        chk("R2 entry command", int'(cmd), 1);
        chk("R3 status not yet", int'(active), 0);
        tick(1);
        chk("R2 command back to NOP", int'(cmd), 0);
        chk("R3 status high", int'(active), 1);
        chk("R3 cke low", int'(cke), 0);
    endtask

    // Raise an access and measure CKE-low cycles and exit wait (R4..R7, R10)
    task automatic do_exit(input string tag, input logic is_rd, input int prog,
                           input int exp_wait, output int low_cnt);
        int k;
        int stall_bad;
        xsnr  = CNT_W'(prog);
        rd    = is_rd;
        valid = 1'b1;
        low_cnt = 0;
        stall_bad = 0;
        while (cke == 1'b0 && low_cnt < 1000) begin
            if (ready) stall_bad++;
            low_cnt++;
            tick(1);
        end
        chk("R4 access stalled while cke low", stall_bad, 0);
        chk("R5 status cleared at exit", int'(active), 0);
        chk("R5 request bit cleared at exit", int'(req), 0);
        k = 0;
        while (!ready && k < 1000) begin
            k++;
            tick(1);
        end
        chk(tag, k, exp_wait);
        valid = 1'b0;
        rd    = 1'b0;
        tick(1);
        chk("R10 idle grant after exit", int'(ready), 1);
        chk("R10 cke high in idle", int'(cke), 1);
        chk("R10 no re-entry", int'(cmd), 0);
    endtask

    task automatic t_reset();
        chk("R1 cke after reset", int'(cke), 1);
        chk("R1 cmd after reset", int'(cmd), 0);
        chk("R1 req after reset", int'(req), 0);
        chk("R1 status after reset", int'(active), 0);
        valid = 1'b1;
        tick(1);
        chk("R1 idle ready", int'(ready), 1);
        chk("R1 idle no error", int'(err), 0);
        gate = 1'b1;
        tick(1);
        chk("R10 idle gated error", int'(err), 1);
        chk("R10 idle gated not ready", int'(ready), 0);
        gate  = 1'b0;
        valid = 1'b0;
        tick(1);
    endtask

    task automatic t_early_write();
        int low;
        enter_sr();
        do_exit("R7 write exit wait", 1'b0, 4, 4, low);
        chk("R4 minimum cke-low time", low, TRAS);
    endtask

    task automatic t_long_read();
        int low;
        enter_sr();
        tick(30);
        chk("R9 still in self-refresh cke", int'(cke), 0);
        chk("R9 still in self-refresh status", int'(active), 1);
        chk("R9 request bit held", int'(req), 1);
        do_exit("R6 read exit wait", 1'b1, 4, TXSRD, low);
        chk("R4 late access wakes at once", low, 1);
    endtask

    task automatic t_zero_prog();
        int low;
        enter_sr();
        tick(10);
        do_exit("R7 zero programmed as one", 1'b0, 0, 1, low);
    endtask

    task automatic t_gated();
        int low;
        enter_sr();
        tick(12);
        gate  = 1'b1;
        valid = 1'b1;
        tick(1);
        chk("R8 gated error", int'(err), 1);
        chk("R8 gated not ready", int'(ready), 0);
        tick(5);
        chk("R8 cke stays low", int'(cke), 0);
        chk("R8 status stays high", int'(active), 1);
        valid = 1'b0;
        gate  = 1'b0;
        tick(1);
        chk("R8 no error after gate off", int'(err), 0);
        do_exit("R7 write exit after gated", 1'b0, 3, 3, low);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_early_write();
        t_long_read();
        t_zero_prog();
        t_gated();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule